// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Domain Fill Levels

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. A small register-file memory holds up to `DEPTH = 2**ADDR_W` words. The write pointer and the read pointer each live in their own domain. Each pointer is turned into a reflected binary (Gray) code before it leaves its domain, and it then passes through two flip-flops clocked by the receiving side.

Both sides get their own status. The write side raises `wr_full` and reports `wr_level`. The read side raises `rd_empty` and reports `rd_level`. Each side builds its level locally: it converts the synchronized Gray pointer from the peer domain back to binary and subtracts it from its own binary pointer. Because the peer pointer arrives late, the write side can over-state how full the FIFO is and the read side can under-state it. Neither side ever errs in the direction that would let it overflow or underflow the memory.

The read port works in show-ahead mode. `rd_data` shows the oldest word whenever `rd_empty` is low, and a `rd_req` pulse removes that word at the next read clock edge. A single active-low asynchronous reset clears both domains.

Top module: `afifo_lvl`

## Requirements
- R1: After reset, `rd_empty` is 1, `wr_full` is 0, and both `wr_level` and `rd_level` are 0.
- R2: Words leave on `rd_data` in the same order they were accepted, with no loss and no duplication. A write is accepted on a `wr_clk` edge where `wr_valid` is 1 and `wr_full` is 0. A read is taken on a `rd_clk` edge where `rd_req` is 1 and `rd_empty` is 0.
- R3: `wr_full` is 1 exactly when `wr_level` equals `DEPTH`. A write attempted while full stores nothing and leaves the write pointer unchanged.
- R4: `rd_empty` is 1 exactly when `rd_level` is 0. A read requested while empty removes nothing and leaves the read pointer unchanged.
- R5: `wr_level` never exceeds `DEPTH`, rises by at most 1 per `wr_clk` cycle, and counts every accepted write in the cycle after it.
- R6: `rd_level` never exceeds `DEPTH`, falls by at most 1 per `rd_clk` cycle, and counts every taken read in the cycle after it.
- R7: At every sample, `wr_level` is at least the true occupancy and `rd_level` is at most the true occupancy.
- R8: Once both sides have been idle for a few cycles of each clock, `wr_level` and `rd_level` both equal the true occupancy.
- R9: Data order and levels stay correct across many wraps of both pointers, because the depth is a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-domain clock |
| wr_valid | input | 1 | Offer `wr_data` for storage |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room; writes are ignored |
| wr_level | output | ADDR_W+1 | Occupancy as seen by the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_req | input | 1 | Remove the word shown on `rd_data` |
| rd_data | output | DATA_W | Oldest stored word (show-ahead) |
| rd_empty | output | 1 | Nothing stored; reads are ignored |
| rd_level | output | ADDR_W+1 | Occupancy as seen by the read side |

## Verification
A read pointer that moved on an empty read shows up one word later as a stale or repeated `rd_data` value. The scoreboard catches this at the very next pop. A write pointer that advanced while full overwrites the oldest unread word. That word then fails its comparison once the FIFO drains, and `rd_empty` also fails to return after the drain. A broken Gray conversion or a mis-wired synchronizer shows up as a level that is wrong after the idle settling window, or as a write-side level below the bench's true count. Either appears within three cycles of the observing clock.

// File: rtl/afifo_lvl.sv
module afifo_lvl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic [ADDR_W:0]   wr_level,
  input  logic              rd_clk,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic [ADDR_W:0]   rd_level
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;

  wire           wr_push = wr_valid & ~wr_full;
  wire           rd_pop  = rd_req & ~rd_empty;
  wire [PW-1:0]  wbin_nx = wbin + PW'(1);
  wire [PW-1:0]  rbin_nx = rbin + PW'(1);

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_push) begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
    end

  always_ff @(posedge wr_clk)
    if (wr_push) mem[wbin[ADDR_W-1:0]] <= wr_data;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_pop) begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
    end

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end

  assign wr_full  = (wgray == {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});
  assign wr_level = wbin - to_bin(rg_s2);
  assign rd_empty = (rgray == wg_s2);
  assign rd_level = to_bin(wg_s2) - rbin;
  assign rd_data  = mem[rbin[ADDR_W-1:0]];
endmodule

// File: rtl/afifo_lvl_chk.sv
module afifo_lvl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic            rst_n,
  input logic            wr_clk,
  input logic            wr_valid,
  input logic            wr_full,
  input logic [ADDR_W:0] wr_level,
  input logic            rd_clk,
  input logic            rd_req,
  input logic            rd_empty,
  input logic [ADDR_W:0] rd_level
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] LVL_MAX = PW'(1 << ADDR_W);

  p_full_at_depth_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_full == (wr_level == LVL_MAX));

  p_full_write_ignored_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_full && wr_valid) |=> (wr_level <= $past(wr_level)));

  p_empty_at_zero_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty == (rd_level == '0));

  p_empty_read_ignored_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_empty && rd_req) |=> (rd_level >= $past(rd_level)));

  p_wr_level_range_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_level <= LVL_MAX);

  p_wr_level_step_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    1'b1 |=> (wr_level <= $past(wr_level) + PW'(1)));

  p_rd_level_range_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_level <= LVL_MAX);

  p_rd_level_step_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    1'b1 |=> (rd_level + PW'(1) >= $past(rd_level)));
endmodule

bind afifo_lvl afifo_lvl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .rst_n(rst_n), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_full(wr_full),
  .wr_level(wr_level), .rd_clk(rd_clk), .rd_req(rd_req), .rd_empty(rd_empty),
  .rd_level(rd_level)
);

// File: tb/afifo_lvl_tb.sv
module afifo_lvl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int DEPTH      = 1 << ADDR_W;

  logic rst_n = 0, wr_clk = 0, rd_clk = 0;
  logic wr_valid = 0, rd_req = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_full, rd_empty;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W:0] wr_level, rd_level;

  int checks = 0, errors = 0;
  int n_push = 0, n_pop = 0;
  int bound_bad = 0;
  logic [DATA_W-1:0] exp_q[$];
  bit rd_en = 0;
  bit force_req = 0;
  int rd_pct = 100;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  afifo_lvl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(wr_full), .wr_level(wr_level), .rd_clk(rd_clk), .rd_req(rd_req),
    .rd_data(rd_data), .rd_empty(rd_empty), .rd_level(rd_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    bit done = 0;
    while (!done) begin
      @(negedge wr_clk);
      wr_valid = 1;
      wr_data  = d;
      done     = !wr_full;
      if (done) exp_q.push_back(d);
      @(posedge wr_clk);
    end
    n_push++;
  endtask

  task automatic wr_idle(input int n);
    repeat (n) begin
      @(negedge wr_clk);
      wr_valid = 0;
    end
  endtask

  // scoreboard monitor: pops and compares on the read side (R2, R9)
  initial begin
    forever begin
      bit go;
      @(negedge rd_clk);
      go = 0;
      if (rd_en) begin
        go = !rd_empty && (($urandom % 100) < rd_pct);
        if (go) begin
          if (exp_q.size() == 0) chk("R2 pop with nothing expected", 1, 0);
          else chk("R2 data order", int'(rd_data), int'(exp_q.pop_front()));
        end
        rd_req = go;
      end else begin
        rd_req = force_req;
      end
      @(posedge rd_clk);
      if (go) n_pop++;
    end
  end

  // R7 safety-side bound monitors
  always @(negedge wr_clk)
    if (rst_n && int'(wr_level) < n_push - n_pop) begin
      bound_bad++;
      $display("FAIL R7 wr_level actual %0d expected >= %0d", wr_level, n_push - n_pop);
    end
  always @(negedge rd_clk)
    if (rst_n && int'(rd_level) > n_push - n_pop) begin
      bound_bad++;
      $display("FAIL R7 rd_level actual %0d expected <= %0d", rd_level, n_push - n_pop);
    end

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    #(3*CLK_PERIOD + 3) rst_n = 1;
    @(negedge wr_clk);
    chk("R1 wr_full", int'(wr_full), 0);
    chk("R1 wr_level", int'(wr_level), 0);
    @(negedge rd_clk);
    chk("R1 rd_empty", int'(rd_empty), 1);
    chk("R1 rd_level", int'(rd_level), 0);

    // fill to the top with the reader stopped
    for (int i = 0; i < DEPTH; i++) push(DATA_W'(i + 8'h10));
    @(negedge wr_clk);
    chk("R3 full at depth", int'(wr_full), 1);
    chk("R5 wr_level at depth", int'(wr_level), DEPTH);
    wr_valid = 1;
    wr_data  = 8'hEE;
    repeat (4) @(negedge wr_clk);
    chk("R3 write while full ignored (level)", int'(wr_level), DEPTH);
    wr_valid = 0;
    settle();
    @(negedge rd_clk);
    chk("R6 rd_level full", int'(rd_level), DEPTH);
    chk("R8 wr_level agrees", int'(wr_level), DEPTH);

    // drain; a write accepted while full would leave a word behind
    rd_pct = 100;
    rd_en  = 1;
    wait (n_pop == DEPTH);
    settle();
    rd_en = 0;
    @(negedge rd_clk);
    chk("R3 no extra word stored while full", int'(rd_empty), 1);
    chk("R4 rd_level empty", int'(rd_level), 0);
    chk("R8 wr_level after drain", int'(wr_level), 0);

    // reads while empty must not move the read pointer
    force_req = 1;
    repeat (5) @(negedge rd_clk);
    force_req = 0;
    settle();
    chk("R4 read while empty ignored (wr side)", int'(wr_level), 0);
    push(8'h5A);
    wr_idle(1);
    settle();
    @(negedge rd_clk);
    chk("R6 rd_level one word", int'(rd_level), 1);
    chk("R4 data after empty reads", int'(rd_data), 8'h5A);
    rd_en = 1;
    wait (n_pop == n_push);

    // streaming with random gaps on both sides, wrapping pointers (R9)
    rd_pct = 60;
    for (int i = 0; i < 300; i++) begin
      push(DATA_W'($urandom));
      if (($urandom % 4) == 0) wr_idle(1 + $urandom % 3);
    end
    wr_idle(1);
    wait (n_pop == n_push);
    settle();
    chk("R9 all words delivered after wraps", exp_q.size(), 0);
    chk("R8 wr_level idle", int'(wr_level), 0);
    @(negedge rd_clk);
    chk("R8 rd_level idle", int'(rd_level), 0);

    // slow reader: writer runs into full repeatedly
    rd_pct = 20;
    for (int i = 0; i < 120; i++) push(DATA_W'(i * 7));
    wr_idle(1);
    wait (n_pop == n_push);
    settle();
    chk("R2 backpressure run complete", exp_q.size(), 0);
    chk("R8 wr_level final", int'(wr_level), 0);
    @(negedge rd_clk);
    chk("R4 empty at end", int'(rd_empty), 1);
    chk("R7 level bounds never crossed", bound_bad, 0);
    summary();
  end
endmodule